// File: doc/BRIEF.md
# Half-Bridge Fault and Power-State Supervisor

This block is the digital supervisor for a multi-channel half-bridge power stage. It turns an active-low reset request, an active-low sleep request, per-channel drive requests and raw protection flags into registered gate-drive enables, run signals for the charge pump and internal clocks, a ready flag and an active-low fault output. The analog sensing and power circuits sit outside. Only their digital flags enter the block.

Each kind of fault recovers in its own way. A channel's current-limit flag must persist past a deglitch interval. It then shuts off that channel alone and stays latched until reset or a supply dip. An overtemperature flag stops every channel and recovers by itself when it clears. A supply undervoltage flag stops every channel and also wipes the latched state. Leaving sleep starts a timed wake-up window, and the gates stay closed until that window ends.

Every asynchronous input passes through a two-flop synchronizer, and every output is registered. A change on an input pin therefore reaches the outputs on the third rising clock edge after it.

Top module: `hb_fault_supervisor`

## Requirements
- R1: While `reset_req_n` is low, `gate_en` is all zero, `ready`, `pump_run` and `clk_run` are 0, and the channel inputs have no effect. Within 6 cycles of release, with sleep inactive, `ready` is 1.
- R2: While `sleep_req_n` is low, `gate_en` is all zero, `pump_run`, `clk_run` and `ready` are 0, and the channel inputs have no effect.
- R3: After `sleep_req_n` rises, `ready` and `gate_en` stay 0 for WAKE_CYC+2 rising edges and become active on edge WAKE_CYC+3.
- R4: An overcurrent flag held for DEGLITCH_CYC cycles or less is ignored. The qualification count restarts whenever the flag drops.
- R5: An overcurrent flag held for DEGLITCH_CYC+1 consecutive cycles latches that channel. Only its `gate_en` bit (bit i for channel i) goes to 0, and `fault_n` goes to 0.
- R6: A latched channel stays off after its flag clears and across sleep. Only a reset or an undervoltage event clears it.
- R7: Overtemperature forces every `gate_en` bit to 0 and `fault_n` to 0. When it clears, the requested channels resume with no reset.
- R8: Undervoltage forces every `gate_en` bit to 0 and `fault_n` to 0, and clears all overcurrent latches. Operation resumes when it clears.
- R9: `fault_n` stays 1 when the only active conditions are reset or sleep.
- R10: `gate_en[i]` is the AND of request i with the conditions awake, not waking, no reset, no undervoltage, no overtemperature and channel i not latched. A request change appears on the third rising edge after the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| reset_req_n | input | 1 | Active-low reset request, asynchronous |
| sleep_req_n | input | 1 | Active-low sleep request, asynchronous |
| ch_en_req | input | NUM_CH | Per-channel drive requests |
| ch_oc_raw | input | NUM_CH | Per-channel raw overcurrent flags |
| over_temp | input | 1 | Overtemperature flag, active high |
| under_volt | input | 1 | Supply undervoltage flag, active high |
| gate_en | output | NUM_CH | Per-channel gate-drive enables |
| pump_run | output | 1 | Charge-pump run request |
| clk_run | output | 1 | Internal clock run request |
| ready | output | 1 | Awake, wake-up window finished |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The bound checker watches the synchronized conditions on every cycle. Overtemperature, undervoltage, sleep and an open wake window must close all gates on the next edge. A latched channel's gate must stay closed, latches may only grow unless undervoltage is present, and the fault output must agree with the fault sources. Some behaviour spans many cycles or crosses the synchronizers, so only the bench scenarios can show it. These are the exact deglitch boundary (DEGLITCH_CYC versus DEGLITCH_CYC+1 cycles), the restart after a dropped flag, the exact edge on which wake-up ends, and the clearing of latches by reset and by a supply dip.

// File: rtl/hbfs_pkg.sv
package hbfs_pkg;

  typedef struct packed {
    logic awake;
    logic over_temp;
    logic under_volt;
  } hbfs_status_t;

  // Next qualification count: saturates at limit, restarts when the flag drops
  function automatic logic [31:0] deglitch_step(input logic flag,
                                                input logic [31:0] cnt,
                                                input logic [31:0] limit);
    if (!flag)             return 32'd0;
    else if (cnt == limit) return cnt;
    else                   return cnt + 32'd1;
  endfunction

  // A fault qualifies once the flag is still high with the count at its limit
  function automatic logic deglitch_trip(input logic flag,
                                         input logic [31:0] cnt,
                                         input logic [31:0] limit);
    return flag && (cnt == limit);
  endfunction

  // Wake countdown: reloads while asleep, counts down to zero once awake
  function automatic logic [31:0] wake_step(input logic awake,
                                            input logic [31:0] cnt,
                                            input logic [31:0] load);
    if (!awake)         return load;
    else if (cnt != 0)  return cnt - 32'd1;
    else                return 32'd0;
  endfunction

  // Global permission shared by all channels
  function automatic logic gate_allow(input hbfs_status_t st, input logic waking);
    return st.awake && !waking && !st.over_temp && !st.under_volt;
  endfunction

endpackage

// File: rtl/hbfs_sync.sv
module hbfs_sync #(
  parameter int                WIDTH   = 1,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/hbfs_wake_timer.sv
module hbfs_wake_timer
  import hbfs_pkg::*;
#(
  parameter int WAKE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic awake,
  output logic waking
);

  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(wake_step(awake, 32'(cnt_q), 32'(WAKE_CYC)));
  end

  assign waking = (cnt_q != '0);

endmodule

// File: rtl/hbfs_oc_chan.sv
module hbfs_oc_chan
  import hbfs_pkg::*;
#(
  parameter int DEGLITCH_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,      // clock domain running (not asleep)
  input  logic clr,      // supply dip wipes state
  input  logic oc_flag,  // synchronized raw flag
  output logic trip,     // qualification event this cycle
  output logic latched
);

  localparam int CW = $clog2(DEGLITCH_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign trip = run && !clr && deglitch_trip(oc_flag, 32'(cnt_q), 32'(DEGLITCH_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      latched <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      latched <= 1'b0;
    end else if (run) begin
      cnt_q <= CW'(deglitch_step(oc_flag, 32'(cnt_q), 32'(DEGLITCH_CYC)));
      if (trip) latched <= 1'b1;
    end
  end

endmodule

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor
  import hbfs_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int DEGLITCH_CYC = 16,
  parameter int WAKE_CYC     = 64
) (
  input  logic              clk,
  input  logic              reset_req_n,
  input  logic              sleep_req_n,
  input  logic [NUM_CH-1:0] ch_en_req,
  input  logic [NUM_CH-1:0] ch_oc_raw,
  input  logic              over_temp,
  input  logic              under_volt,
  output logic [NUM_CH-1:0] gate_en,
  output logic              pump_run,
  output logic              clk_run,
  output logic              ready,
  output logic              fault_n
);

  // Reset request: asserts at once, releases through two flops
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge reset_req_n) begin
    if (!reset_req_n) rst_pipe <= 2'b00;
    else              rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  // Synchronized inputs
  logic [NUM_CH-1:0] en_s;
  logic [NUM_CH-1:0] oc_s;
  hbfs_status_t      st_raw;
  hbfs_status_t      st_s;

  assign st_raw = '{awake: sleep_req_n, over_temp: over_temp, under_volt: under_volt};

  hbfs_sync #(.WIDTH(NUM_CH), .RST_VAL('0)) u_sync_en (
    .clk(clk), .rst_n(rst_n_int), .d(ch_en_req), .q(en_s));

  hbfs_sync #(.WIDTH(NUM_CH), .RST_VAL('0)) u_sync_oc (
    .clk(clk), .rst_n(rst_n_int), .d(ch_oc_raw), .q(oc_s));

  hbfs_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync_st (
    .clk(clk), .rst_n(rst_n_int), .d(st_raw), .q(st_s));

  // Named internal events
  logic              sleep_s;
  logic              ot_s;
  logic              uv_s;
  logic              waking;
  logic              awake_ok;
  logic [NUM_CH-1:0] trip_vec;
  logic [NUM_CH-1:0] oc_latch;
  logic              fault_cond;
  logic [NUM_CH-1:0] gate_next;

  assign sleep_s = st_s.awake;
  assign ot_s    = st_s.over_temp;
  assign uv_s    = st_s.under_volt;

  hbfs_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n_int), .awake(sleep_s), .waking(waking));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    hbfs_oc_chan #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_oc (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .run     (sleep_s),
      .clr     (uv_s),
      .oc_flag (oc_s[ch]),
      .trip    (trip_vec[ch]),
      .latched (oc_latch[ch])
    );
  end

  assign awake_ok   = sleep_s && !waking;
  assign fault_cond = (|oc_latch) || ot_s || uv_s;
  assign gate_next  = en_s & ~oc_latch & {NUM_CH{gate_allow(st_s, waking)}};

  // Registered outputs
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      gate_en  <= '0;
      pump_run <= 1'b0;
      clk_run  <= 1'b0;
      ready    <= 1'b0;
      fault_n  <= 1'b1;
    end else begin
      gate_en  <= gate_next;
      pump_run <= sleep_s;
      clk_run  <= sleep_s;
      ready    <= awake_ok;
      fault_n  <= !fault_cond;
    end
  end

endmodule

// File: rtl/hbfs_checker.sv
module hbfs_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              sleep_s,
  input logic              ot_s,
  input logic              uv_s,
  input logic              waking,
  input logic [NUM_CH-1:0] trip_vec,
  input logic [NUM_CH-1:0] oc_latch,
  input logic [NUM_CH-1:0] gate_en,
  input logic              pump_run,
  input logic              clk_run,
  input logic              ready,
  input logic              fault_n
);

  // R1
  always @(negedge clk) begin
    if (!rst_n_int) begin
      rst_quiet_chk: assert (gate_en == '0 && !ready && !pump_run && !clk_run && fault_n);
    end
  end

  // R2
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !sleep_s |=> (gate_en == '0 && !pump_run && !clk_run && !ready));

  // R3
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    waking |=> (gate_en == '0 && !ready));

  // R5
  trip_latch_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (trip_vec != '0 && !uv_s) |=> ((oc_latch & $past(trip_vec)) == $past(trip_vec)));

  // R5
  latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (oc_latch != '0) |=> ((gate_en & $past(oc_latch)) == '0 && !fault_n));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !uv_s |=> ((oc_latch & $past(oc_latch)) == $past(oc_latch)));

  // R7
  ot_off_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ot_s |=> (gate_en == '0 && !fault_n));

  // R8
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    uv_s |=> (gate_en == '0 && !fault_n && oc_latch == '0));

  // R9
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!ot_s && !uv_s && oc_latch == '0) |=> fault_n);

endmodule

bind hb_fault_supervisor hbfs_checker #(.NUM_CH(NUM_CH)) u_hbfs_chk (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .sleep_s   (sleep_s),
  .ot_s      (ot_s),
  .uv_s      (uv_s),
  .waking    (waking),
  .trip_vec  (trip_vec),
  .oc_latch  (oc_latch),
  .gate_en   (gate_en),
  .pump_run  (pump_run),
  .clk_run   (clk_run),
  .ready     (ready),
  .fault_n   (fault_n)
);

// File: tb/test_hb_fault_supervisor.sv
module test_hb_fault_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int DGL  = 16;
  localparam int WAKE = 64;

  logic           clk = 1'b0;
  logic           reset_req_n;
  logic           sleep_req_n;
  logic [NCH-1:0] ch_en_req;
  logic [NCH-1:0] ch_oc_raw;
  logic           over_temp;
  logic           under_volt;
  logic [NCH-1:0] gate_en;
  logic           pump_run;
  logic           clk_run;
  logic           ready;
  logic           fault_n;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_fault_supervisor #(.NUM_CH(NCH), .DEGLITCH_CYC(DGL), .WAKE_CYC(WAKE)) i_hb_fault_supervisor (
    .clk(clk), .reset_req_n(reset_req_n), .sleep_req_n(sleep_req_n),
    .ch_en_req(ch_en_req), .ch_oc_raw(ch_oc_raw), .over_temp(over_temp),
    .under_volt(under_volt), .gate_en(gate_en), .pump_run(pump_run),
    .clk_run(clk_run), .ready(ready), .fault_n(fault_n));

  // {en[3:0], ot, uv, exp_gate[3:0], exp_fault_n}
  localparam logic [10:0] VEC [8] = '{
    {4'hF, 1'b0, 1'b0, 4'hF, 1'b1},
    {4'h5, 1'b0, 1'b0, 4'h5, 1'b1},
    {4'hA, 1'b0, 1'b0, 4'hA, 1'b1},
    {4'hF, 1'b1, 1'b0, 4'h0, 1'b0},
    {4'hF, 1'b0, 1'b0, 4'hF, 1'b1},
    {4'hF, 1'b0, 1'b1, 4'h0, 1'b0},
    {4'h3, 1'b0, 1'b0, 4'h3, 1'b1},
    {4'h0, 1'b0, 1'b0, 4'h0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic oc_pulse(input int ch, input int len);
    ch_oc_raw[ch] = 1'b1;
    cycles(len);
    ch_oc_raw[ch] = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    reset_req_n = 1'b0; sleep_req_n = 1'b1; ch_en_req = '0;
    ch_oc_raw = '0; over_temp = 1'b0; under_volt = 1'b0;
    cycles(3);
    // R1: requests and faults during reset have no effect
    ch_en_req = 4'hF; over_temp = 1'b1;
    cycles(5);
    check("R1 gate in reset", 32'(gate_en), 32'h0);
    check("R1 ready in reset", 32'(ready), 32'h0);
    check("R1 pump in reset", 32'(pump_run), 32'h0);
    check("R9 fault_n in reset", 32'(fault_n), 32'h1);
    over_temp = 1'b0;
    reset_req_n = 1'b1;
    cycles(6);
    check("R1 ready after release", 32'(ready), 32'h1);

    // Vector table: R7 R8 R10 steady states
    for (int i = 0; i < 8; i++) begin
      ch_en_req  = VEC[i][10:7];
      over_temp  = VEC[i][6];
      under_volt = VEC[i][5];
      cycles(6);
      check("R10/R7/R8 gate vector", 32'(gate_en), 32'(VEC[i][4:1]));
      check("R7/R8/R9 fault vector", 32'(fault_n), 32'(VEC[i][0]));
    end

    // R10 latency: third edge after the pin change
    ch_en_req = 4'hF;
    cycles(2);
    check("R10 gate before third edge", 32'(gate_en), 32'h0);
    cycles(1);
    check("R10 gate on third edge", 32'(gate_en), 32'hF);

    // R2 sleep
    sleep_req_n = 1'b0;
    cycles(5);
    ch_en_req = 4'h6;
    cycles(5);
    check("R2 gate asleep", 32'(gate_en), 32'h0);
    check("R2 pump asleep", 32'(pump_run), 32'h0);
    check("R2 clk_run asleep", 32'(clk_run), 32'h0);
    check("R2 ready asleep", 32'(ready), 32'h0);
    check("R9 fault_n asleep", 32'(fault_n), 32'h1);
    ch_en_req = 4'hF;

    // R3 wake window
    sleep_req_n = 1'b1;
    cycles(WAKE + 2);
    check("R3 ready still low", 32'(ready), 32'h0);
    check("R3 gate still off", 32'(gate_en), 32'h0);
    check("R3 pump running", 32'(pump_run), 32'h1);
    cycles(1);
    check("R3 ready high", 32'(ready), 32'h1);
    check("R3 gate on", 32'(gate_en), 32'hF);

    // R4 short pulse and restart
    oc_pulse(2, DGL);
    cycles(6);
    check("R4 short pulse gate", 32'(gate_en), 32'hF);
    check("R4 short pulse fault", 32'(fault_n), 32'h1);
    oc_pulse(2, DGL);
    cycles(1);
    oc_pulse(2, DGL);
    cycles(6);
    check("R4 restart gate", 32'(gate_en), 32'hF);
    check("R4 restart fault", 32'(fault_n), 32'h1);

    // R5 qualified overcurrent on channel 1
    oc_pulse(1, DGL + 1);
    cycles(6);
    check("R5 only ch1 off", 32'(gate_en), 32'hD);
    check("R5 fault low", 32'(fault_n), 32'h0);

    // R6 persistence, including across sleep
    cycles(20);
    check("R6 latch holds", 32'(gate_en), 32'hD);
    sleep_req_n = 1'b0;
    cycles(6);
    sleep_req_n = 1'b1;
    cycles(WAKE + 6);
    check("R6 latch holds over sleep", 32'(gate_en), 32'hD);
    check("R6 fault holds over sleep", 32'(fault_n), 32'h0);

    // R8 supply dip clears the latch
    under_volt = 1'b1;
    cycles(6);
    check("R8 gate off under uv", 32'(gate_en), 32'h0);
    check("R8 fault under uv", 32'(fault_n), 32'h0);
    under_volt = 1'b0;
    cycles(6);
    check("R8 gate after uv", 32'(gate_en), 32'hF);
    check("R8 fault after uv", 32'(fault_n), 32'h1);

    // R6 reset clears a latch on channel 3
    oc_pulse(3, DGL + 1);
    cycles(6);
    check("R5 only ch3 off", 32'(gate_en), 32'h7);
    reset_req_n = 1'b0;
    cycles(3);
    reset_req_n = 1'b1;
    cycles(6);
    check("R6 gate after reset", 32'(gate_en), 32'hF);
    check("R6 fault after reset", 32'(fault_n), 32'h1);

    finish_run();
  end

endmodule